// File: doc/BRIEF.md
# Burst DMA Write Engine

This block is the write half of a DMA channel. It takes one transfer command at a time: a destination address, a length in bytes and a flag that chooses between an incrementing and a fixed destination. The data for the command arrives on a valid/ready streaming sink that carries an end-of-packet marker. The engine stores that data in an internal write FIFO. It then sends the data to memory as bursts on a memory-mapped write master that can stall each beat with a wait-request input.

Bursts have a fixed size of `BURST_MAX` beats. Only the last burst of a command may be shorter, and it carries whatever remains. If end-of-packet arrives before the requested length, the command stops early. When a command ends, the engine pulses a status output that holds the number of bytes it actually wrote and a flag that is set when fewer bytes were written than requested. The next command is accepted only after that status pulse.

Top module: `burst_wr_engine`

## Requirements
- R1: `cmd_ready` is high only while the engine is idle. A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both high. No further command is taken until that command's status has been pulsed.
- R2: `cmd_len` is a byte count. The beat count is `cmd_len / (DATA_W/8)`, and the low `log2(DATA_W/8)` bits of `cmd_len` are ignored.
- R3: `m_burstcount` is always between 1 and `BURST_MAX`. Every burst of a command has exactly `BURST_MAX` beats, except the final burst, which has the remaining beat count.
- R4: A burst starts, meaning `m_write` rises, only when the write FIFO already holds at least `m_burstcount` beats.
- R5: When `cmd_incr`=1, the first beat goes to `cmd_addr`, and `m_addr` advances by `DATA_W/8` after every accepted beat. When `cmd_incr`=0, every beat goes to `cmd_addr`.
- R6: Stream beats are written in the order they were accepted, with their data unchanged. No beat is lost and no beat is duplicated.
- R7: `s_ready` is high while a command is active and its input is incomplete. It is low once end-of-packet or the last requested beat has been accepted, and low while the engine is idle. An end-of-packet beat ends the command after that beat.
- R8: The write FIFO holds `2*BURST_MAX` beats, and `s_ready` is low whenever it is full.
- R9: `st_valid` is a single-cycle pulse. With it, `st_bytes` equals the beats written times `DATA_W/8`, and `st_short` is 1 exactly when fewer beats were written than requested.
- R10: While `m_write`=1 and `m_waitrequest`=1, the next cycle keeps `m_write`, `m_addr`, `m_wdata` and `m_burstcount` unchanged.
- R11: A command of zero beats performs no write. It produces a status with `st_bytes`=0 and `st_short`=0.
- R12: After reset, `cmd_ready`=1, `s_ready`=0, `m_write`=0 and `st_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken |
| cmd_addr | input | ADDR_W | Destination byte address |
| cmd_len | input | LEN_W | Requested length in bytes |
| cmd_incr | input | 1 | 1: destination increments per beat, 0: fixed |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Engine accepts a stream beat |
| s_data | input | DATA_W | Stream beat data |
| s_eop | input | 1 | Beat is the last of its packet |
| m_write | output | 1 | Write beat presented |
| m_addr | output | ADDR_W | Address of the current beat |
| m_wdata | output | DATA_W | Data of the current beat |
| m_burstcount | output | $clog2(BURST_MAX+1) | Beats in the current burst |
| m_waitrequest | input | 1 | Memory stalls the current beat |
| st_valid | output | 1 | Status pulse for the finished command |
| st_bytes | output | LEN_W | Bytes actually written |
| st_short | output | 1 | Fewer bytes written than requested |

## Verification
The bench builds the engine with a 32-bit datapath, `BURST_MAX`=4 and a 12-bit length. The FIFO therefore fills after 8 beats. That is enough to hold it full behind a long wait-request stall, and to produce remainders of 1, 2 and 3 beats. The small burst size allows lengths above, below and equal to a whole number of bursts in few cycles. The same commands are also run with end-of-packet placed early, on the final beat, and inside the first burst. The cases mix gaps in the stream and random stalls.

// File: rtl/bwe_pkg.sv
package bwe_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FILL   = 2'd1,
        PH_BURST  = 2'd2,
        PH_REPORT = 2'd3
    } phase_e;

endpackage

// File: rtl/bwe_wr_fifo.sv
module bwe_wr_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fptr_t;

    fptr_t        f_d, f_q;
    logic [W-1:0] store_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        f_d = f_q;
        if (wr_en) f_d.wp = bump(f_q.wp);
        if (rd_en) f_d.rp = bump(f_q.rp);
        case ({wr_en, rd_en})
            2'b10:   f_d.cnt = f_q.cnt + CNT_W'(1);
            2'b01:   f_d.cnt = f_q.cnt - CNT_W'(1);
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) store_q[f_q.wp] <= wr_data;
    end

    assign rd_data = store_q[f_q.rp];
    assign count   = f_q.cnt;
    assign full    = (f_q.cnt == CNT_W'(DEPTH));

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (f_q.cnt != CNT_W'(DEPTH))); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (f_q.cnt != '0)); // R6

endmodule

// File: rtl/bwe_burst_plan.sv
module bwe_burst_plan #(
    parameter int BEAT_W    = 12,
    parameter int BURST_MAX = 4,
    localparam int BC_W  = $clog2(BURST_MAX + 1),
    localparam int CNT_W = $clog2(2 * BURST_MAX + 1)
) (
    input  logic              in_done,
    input  logic [BEAT_W-1:0] total,
    input  logic [BEAT_W-1:0] in_cnt,
    input  logic [BEAT_W-1:0] out_cnt,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic [BC_W-1:0]   blen,
    output logic              go,
    output logic              finished
);

    logic [BEAT_W-1:0] target;
    logic [BEAT_W-1:0] rem;

    always_comb begin
        // once the stream has ended, the beats already taken are the goal
        target   = in_done ? in_cnt : total;
        rem      = target - out_cnt;
        blen     = (rem >= BEAT_W'(BURST_MAX)) ? BC_W'(BURST_MAX) : rem[BC_W-1:0];
        go       = (rem != '0) && (fifo_count >= CNT_W'(blen));
        finished = in_done && (rem == '0);
    end

endmodule

// File: rtl/burst_wr_engine.sv
module burst_wr_engine
    import bwe_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 12,
    parameter int BURST_MAX = 4,
    localparam int BYTES = DATA_W / 8,
    localparam int BSH   = $clog2(BYTES),
    localparam int DEPTH = 2 * BURST_MAX,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int BC_W  = $clog2(BURST_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_incr,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_eop,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic [BC_W-1:0]   m_burstcount,
    input  logic              m_waitrequest,
    output logic              st_valid,
    output logic [LEN_W-1:0]  st_bytes,
    output logic              st_short
);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  total;
        logic [LEN_W-1:0]  in_cnt;
        logic [LEN_W-1:0]  out_cnt;
        logic [BC_W-1:0]   left;
        logic [BC_W-1:0]   blen;
        logic              incr;
        logic              in_done;
    } ctx_t;

    ctx_t c_d, c_q;

    logic             push, pop;
    logic             fifo_full;
    logic [CNT_W-1:0] fifo_count;
    logic [BC_W-1:0]  plan_blen;
    logic             plan_go, plan_finished;

    bwe_wr_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (s_data),
        .rd_en   (pop),
        .rd_data (m_wdata),
        .count   (fifo_count),
        .full    (fifo_full)
    );

    bwe_burst_plan #(.BEAT_W(LEN_W), .BURST_MAX(BURST_MAX)) u_plan (
        .in_done    (c_q.in_done),
        .total      (c_q.total),
        .in_cnt     (c_q.in_cnt),
        .out_cnt    (c_q.out_cnt),
        .fifo_count (fifo_count),
        .blen       (plan_blen),
        .go         (plan_go),
        .finished   (plan_finished)
    );

    always_comb begin
        cmd_ready    = (c_q.ph == PH_IDLE);
        s_ready      = ((c_q.ph == PH_FILL) || (c_q.ph == PH_BURST))
                       && !c_q.in_done && !fifo_full;
        m_write      = (c_q.ph == PH_BURST);
        m_addr       = c_q.addr;
        m_burstcount = c_q.blen;
        st_valid     = (c_q.ph == PH_REPORT);
        st_bytes     = c_q.out_cnt << BSH;
        st_short     = (c_q.out_cnt != c_q.total);
        push         = s_valid && s_ready;
        pop          = m_write && !m_waitrequest;
    end

    always_comb begin
        c_d = c_q;

        // stream side runs in parallel with the burst phases
        if (push) begin
            c_d.in_cnt = c_q.in_cnt + LEN_W'(1);
            if (s_eop || (c_q.in_cnt + LEN_W'(1) == c_q.total)) c_d.in_done = 1'b1;
        end

        case (c_q.ph)
            PH_IDLE: begin
                if (cmd_valid) begin
                    c_d.ph      = PH_FILL;
                    c_d.addr    = cmd_addr;
                    c_d.total   = cmd_len >> BSH;
                    c_d.incr    = cmd_incr;
                    c_d.in_cnt  = '0;
                    c_d.out_cnt = '0;
                    c_d.in_done = ((cmd_len >> BSH) == '0);
                end
            end
            PH_FILL: begin
                if (plan_finished) begin
                    c_d.ph = PH_REPORT;
                end else if (plan_go) begin
                    c_d.ph   = PH_BURST;
                    c_d.blen = plan_blen;
                    c_d.left = plan_blen;
                end
            end
            PH_BURST: begin
                if (pop) begin
                    c_d.out_cnt = c_q.out_cnt + LEN_W'(1);
                    c_d.left    = c_q.left - BC_W'(1);
                    if (c_q.incr) c_d.addr = c_q.addr + ADDR_W'(BYTES);
                    if (c_q.left == BC_W'(1)) c_d.ph = PH_FILL;
                end
            end
            default: begin
                c_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && m_waitrequest) |=> (m_write && $stable(m_addr)
            && $stable(m_wdata) && $stable(m_burstcount))); // R10
    AST_BURST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        m_write |-> ((m_burstcount != '0) && (m_burstcount <= BC_W'(BURST_MAX)))); // R3
    AST_BURST_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_write) |-> (fifo_count >= CNT_W'(m_burstcount))); // R4
    AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> !st_valid); // R9
    AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (m_write && !m_waitrequest && !c_q.incr) |=> $stable(m_addr)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!m_write && !st_valid)); // R1

endmodule

// File: tb/burst_wr_engine_bench.sv
`timescale 1ns/1ps
module burst_wr_engine_bench;

    localparam int DATA_W = 32, ADDR_W = 32, LEN_W = 12, BURST_MAX = 4;
    localparam int BYTES = DATA_W / 8;
    localparam int DEPTH = 2 * BURST_MAX;
    localparam int BC_W  = $clog2(BURST_MAX + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_incr = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic s_valid = 1'b0, s_eop = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic m_waitrequest = 1'b0;
    logic cmd_ready, s_ready, m_write, st_valid, st_short;
    logic [ADDR_W-1:0] m_addr;
    logic [DATA_W-1:0] m_wdata;
    logic [BC_W-1:0]   m_burstcount;
    logic [LEN_W-1:0]  st_bytes;

    burst_wr_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_MAX(BURST_MAX))
    u_burst_wr_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_incr(cmd_incr),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_eop(s_eop),
        .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_burstcount(m_burstcount), .m_waitrequest(m_waitrequest),
        .st_valid(st_valid), .st_bytes(st_bytes), .st_short(st_short)
    );

    always #2.5 clk = ~clk;

    int n_checks = 0, n_errors = 0;
    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // reference model state
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    int  e_cur = 0, len_cur = 0, wr_cnt = 0, acc_in_cmd = 0;
    int  acc_in = 0, acc_out = 0, bleft = 0;
    bit  active = 0, st_seen = 0, s_hs = 0, c_hs = 0, prev_st = 0;
    bit  hold_pend = 0;
    logic [ADDR_W-1:0] h_addr;
    logic [DATA_W-1:0] h_data;
    logic [BC_W-1:0]   h_bc;

    always @(negedge clk) begin
        if (rst_n) begin
            s_hs = s_valid && s_ready;
            c_hs = cmd_valid && cmd_ready;
            if (hold_pend)
                check(m_write && m_addr == h_addr && m_wdata == h_data && m_burstcount == h_bc,
                      "R10 beat held under wait", m_addr, h_addr);
            hold_pend = m_write && m_waitrequest;
            h_addr = m_addr; h_data = m_wdata; h_bc = m_burstcount;

            if (acc_in - acc_out == DEPTH)
                check(!s_ready, "R8 ready low when FIFO full", s_ready, 0);
            else if (active && acc_in_cmd < e_cur)
                check(s_ready, "R7 ready while input incomplete", s_ready, 1);
            else
                check(!s_ready, "R7 ready low after input end or idle", s_ready, 0);

            if (m_write && bleft == 0) begin
                int exp_bc;
                exp_bc = (e_cur - wr_cnt) < BURST_MAX ? (e_cur - wr_cnt) : BURST_MAX;
                check(int'(m_burstcount) == exp_bc, "R3 burst size", m_burstcount, exp_bc);
                check(acc_in - acc_out >= int'(m_burstcount), "R4 burst data buffered",
                      acc_in - acc_out, m_burstcount);
                bleft = int'(m_burstcount);
            end
            if (m_write && !m_waitrequest) begin
                if (q_addr.size() == 0) begin
                    check(0, "R6 unexpected write beat", m_addr, 0);
                end else begin
                    logic [31:0] ea, ed;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    check(m_addr == ea, "R5 beat address", m_addr, ea);
                    check(m_wdata == ed, "R6 beat data", m_wdata, ed);
                end
                bleft--; wr_cnt++; acc_out++;
            end

            if (prev_st) check(!st_valid, "R9 status one cycle", st_valid, 0);
            if (st_valid) begin
                check(int'(st_bytes) == e_cur * BYTES, "R9 status bytes", st_bytes, e_cur * BYTES);
                check(st_short == (e_cur != len_cur), "R9 status short flag", st_short, e_cur != len_cur);
                check(wr_cnt == e_cur && q_addr.size() == 0, "R6 all beats written", wr_cnt, e_cur);
                st_seen = 1; active = 0;
            end
            prev_st = st_valid;
            if (s_hs) begin acc_in++; acc_in_cmd++; end
            if (c_hs) active = 1;
        end
    end

    // wait-request generator: 0 none, 1 pseudo-random, 2 held
    int wmode = 0;
    logic [7:0] lfsr = 8'h5a;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        m_waitrequest = (wmode == 2) || (wmode == 1 && lfsr[0] && lfsr[2]);
    end

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            check(0, "watchdog expired", cycles, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic run_cmd(input int id, input int len_bytes, input bit incr, input int eop_at,
                           input bit gaps, input int wm, input int hold);
        int beats, eff;
        logic [31:0] base;
        beats = len_bytes / BYTES;
        eff   = (eop_at >= 0 && eop_at < beats) ? eop_at + 1 : beats;
        base  = 32'h1000_0000 + 32'(id) * 32'h100;
        for (int i = 0; i < eff; i++) begin
            q_addr.push_back(incr ? base + 32'(i * BYTES) : base);
            q_data.push_back({8'(id), 24'(i * 7 + 3)});
        end
        e_cur = eff; len_cur = beats; wr_cnt = 0; acc_in_cmd = 0; bleft = 0; st_seen = 0;
        wmode = wm;
        @(posedge clk); #1;
        cmd_valid = 1; cmd_addr = base; cmd_len = LEN_W'(len_bytes); cmd_incr = incr;
        do begin @(posedge clk); #1; end while (!c_hs);
        cmd_valid = 0;
        fork
            begin
                for (int i = 0; i < eff; i++) begin
                    s_valid = 1; s_data = {8'(id), 24'(i * 7 + 3)};
                    s_eop = (i == eop_at);
                    do begin @(posedge clk); #1; end while (!s_hs);
                    s_valid = 0; s_eop = 0;
                    if (gaps && i[0]) begin @(posedge clk); #1; end
                end
            end
            begin
                if (hold > 0) begin
                    wmode = 2;
                    repeat (hold) @(posedge clk);
                    wmode = 1;
                end
            end
        join
        while (!st_seen) @(posedge clk);
        wmode = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        check(cmd_ready == 1, "R12 cmd_ready after reset", cmd_ready, 1);
        check(s_ready == 0, "R12 s_ready after reset", s_ready, 0);
        check(m_write == 0, "R12 m_write after reset", m_write, 0);
        check(st_valid == 0, "R12 st_valid after reset", st_valid, 0);
        rst_n = 1;
        run_cmd(1, 64, 1, -1, 0, 0, 0);  // R3 whole bursts
        run_cmd(2, 40, 1, -1, 1, 1, 0);  // R3 remainder 2, R1
        run_cmd(3, 28, 0, -1, 0, 1, 0);  // R5 fixed address, remainder 3
        run_cmd(4, 48, 1, 5, 0, 1, 0);   // R7 early end-of-packet
        run_cmd(5, 80, 1, 2, 1, 0, 0);   // R7 end-of-packet in first burst
        run_cmd(6, 32, 1, 7, 0, 1, 0);   // R9 eop on final beat, not short
        run_cmd(7, 0, 1, -1, 0, 0, 0);   // R11 zero length
        run_cmd(8, 23, 1, -1, 0, 0, 0);  // R2 low length bits ignored
        run_cmd(9, 80, 1, -1, 0, 1, 30); // R8 FIFO fills behind stall, R10
        run_cmd(10, 4, 0, -1, 0, 1, 0);  // R3 single-beat burst
        repeat (5) @(posedge clk);
        check(cmd_ready == 1, "R1 idle after last command", cmd_ready, 1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule